// File: doc/BRIEF.md
# Nine-Bit Word Buffer with Wrapping Level Count

This block is an eight-deep first-in first-out store of nine-bit words. A serial bus controller uses it as the staging area between software and the shifter, in either direction. On the way out, an eight-bit byte is placed in bits 8:1 and bit 0 is forced to 1, so the line is released during the acknowledge slot. On the way in, the popped word carries the received byte in bits 8:1 and the sampled acknowledge in bit 0.

The occupancy is reported on a three-bit level port, which can only count from 0 to 7. A completely filled store therefore reports level 0, and only the separate full flag tells it apart from an empty one. A half-full flag is also provided so that it can be used as an interrupt source.

A synchronous soft-reset input empties the store. Software is expected to drain the store before using it. If the soft reset arrives while words remain, a sticky busy error is raised. Misuse of the push and pop ports is recorded in sticky overflow and underflow bits.

Top module: `nbf_top`

## Requirements
- R1: After `rst`, level is 0, `full`, `half_full`, `overflow`, `underflow` and `busy_err` are 0, and `rd_data` is 0.
- R2: Words leave in the order they entered. A pop that is accepted at a clock edge presents the oldest word on `rd_data` from that edge on.
- R3: `level` equals the occupancy modulo 8, and `full` is 1 exactly when 8 words are held. A full store reads level 0.
- R4: `half_full` is 1 exactly when the occupancy is 4 or more.
- R5: A push when 8 words are held and no pop is accepted is dropped: the occupancy and contents are unchanged, and the sticky `overflow` bit is set.
- R6: A pop from an empty store changes nothing in the store, sets the sticky `underflow` bit and drives `rd_data` to 0.
- R7: A push and a pop in the same cycle on a non-empty store leave the occupancy unchanged. This includes the full case, where the pushed word is kept. On an empty store, the push is accepted and the pop counts as an underflow.
- R8: `soft_rst` empties the store and clears `overflow` and `underflow`. It takes priority over a push or pop in the same cycle, and it leaves `rd_data` unchanged.
- R9: `soft_rst` while the store holds at least one word sets `busy_err`. `soft_rst` while empty clears it.
- R10: With `byte_mode` = 1, the stored word is `{wr_data[7:0], 1'b1}`. With `byte_mode` = 0, the full nine-bit `wr_data` is stored.
- R11: `rd_data` holds its value in every cycle without a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous empty request, checked for misuse |
| push | input | 1 | Write request |
| byte_mode | input | 1 | 1: pack wr_data[7:0] with a released acknowledge bit |
| wr_data | input | 9 | Word (or byte in low bits) to write |
| pop | input | 1 | Read request |
| rd_data | output | 9 | Last popped word, 0 after an empty pop |
| level | output | 3 | Occupancy modulo 8 |
| full | output | 1 | Eight words held |
| half_full | output | 1 | At least four words held |
| overflow | output | 1 | Sticky dropped-push flag |
| underflow | output | 1 | Sticky empty-pop flag |
| busy_err | output | 1 | Sticky soft reset with data present flag |

## Verification
Push and pop can fall in the same cycle, and soft reset can coincide with either of them. The bench provokes all three combinations deliberately: it issues simultaneous push and pop at the full and empty boundaries and in between, and it asserts soft reset with requests pending. It then runs a long random mix. A behavioural queue model predicts occupancy, flags and read data for each edge. Every output is compared against that model on every cycle, so both the accept/drop decision and the order of pop-before-push at the full boundary are judged directly.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  typedef struct packed {
    logic ovf;
    logic udf;
    logic busy;
  } nbf_sticky_t;
endpackage

// File: rtl/nbf_mem.sv
module nbf_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= store[ra];
  end
endmodule

// File: rtl/nbf_ctrl.sv
module nbf_ctrl
  import nbf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_zero,
  output logic [CW-1:0] count,
  output nbf_sticky_t   sticky
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic pop_ok, push_ok;

  always_comb begin
    pop_ok  = pop && (count != '0);
    push_ok = push && ((count != FULL_CNT) || pop_ok);
    wr_en   = push_ok && !soft_rst;
    rd_en   = pop_ok && !soft_rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
      rd_zero <= 1'b1;
      sticky  <= '0;
    end else if (soft_rst) begin
      wr_addr     <= '0;
      rd_addr     <= '0;
      count       <= '0;
      sticky.ovf  <= 1'b0;
      sticky.udf  <= 1'b0;
      sticky.busy <= (count != '0);
    end else begin
      if (push_ok) wr_addr <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
      if (pop_ok)  rd_addr <= (rd_addr == LAST) ? '0 : rd_addr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push && !push_ok) sticky.ovf <= 1'b1;
      if (pop && !pop_ok)   sticky.udf <= 1'b1;
      if (pop)              rd_zero    <= !pop_ok;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  assert_drop_on_full_R5: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && push && !pop && !soft_rst) |=> (count == FULL_CNT && sticky.ovf));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && pop && !push && !soft_rst) |=> (count == '0 && sticky.udf));
  assert_balance_R7: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && push && pop && !soft_rst) |=> $stable(count));
  assert_soft_empty_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (count == '0 && !sticky.ovf && !sticky.udf));
  assert_busy_set_R9: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && count != '0) |=> sticky.busy);
endmodule

// File: rtl/nbf_top.sv
module nbf_top
  import nbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             push,
  input  logic             byte_mode,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [AW-1:0]    level,
  output logic             full,
  output logic             half_full,
  output logic             overflow,
  output logic             underflow,
  output logic             busy_err
);
  logic             wr_en, rd_en, rd_zero;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] word_in, mem_q;
  nbf_sticky_t      sticky;

  always_comb word_in = byte_mode ? {wr_data[WIDTH-2:0], 1'b1} : wr_data;

  nbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .push(push), .pop(pop),
    .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_zero(rd_zero), .count(count), .sticky(sticky)
  );

  nbf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk(clk), .rst(rst), .we(wr_en), .wa(wr_addr), .wd(word_in),
    .re(rd_en), .ra(rd_addr), .q(mem_q)
  );

  always_comb begin
    rd_data   = rd_zero ? '0 : mem_q;
    level     = count[AW-1:0];
    full      = (count == CW'(DEPTH));
    half_full = (count >= CW'(DEPTH / 2));
    overflow  = sticky.ovf;
    underflow = sticky.udf;
    busy_err  = sticky.busy;
  end

  assert_full_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> (level == '0 && half_full));
  assert_zero_on_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && !soft_rst && count == '0) |=> (rd_data == '0));
  assert_hold_rd_R11: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(rd_data));
endmodule

// File: tb/test_nbf_top.sv
module test_nbf_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0, push = 1'b0, pop = 1'b0, byte_mode = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic [2:0] level;
  logic       full, half_full, overflow, underflow, busy_err;

  int checks = 0;
  int errors = 0;

  logic [8:0] mq[$];
  logic [8:0] m_rd = '0;
  logic       m_ovf = 0, m_udf = 0, m_busy = 0;

  always #4 clk = ~clk;

  nbf_top i_nbf_top (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .push(push), .byte_mode(byte_mode),
    .wr_data(wr_data), .pop(pop), .rd_data(rd_data), .level(level), .full(full),
    .half_full(half_full), .overflow(overflow), .underflow(underflow), .busy_err(busy_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 level", level, mq.size() % 8);
    chk("R3 full", full, mq.size() == 8);
    chk("R4 half_full", half_full, mq.size() >= 4);
    chk("R5 overflow", overflow, m_ovf);
    chk("R6 underflow", underflow, m_udf);
    chk("R9 busy_err", busy_err, m_busy);
    chk("R2 R6 R8 R10 R11 rd_data", rd_data, m_rd);
  endtask

  // Drive one cycle of stimulus, advance the model across the edge, compare after it.
  task automatic step(input logic s, input logic pu, input logic po,
                      input logic bm, input logic [8:0] d);
    logic       pop_ok, push_ok;
    logic [8:0] w;
    soft_rst = s; push = pu; pop = po; byte_mode = bm; wr_data = d;
    w = bm ? {d[7:0], 1'b1} : d;
    if (s) begin
      m_busy = (mq.size() != 0);
      mq.delete();
      m_ovf = 0; m_udf = 0;
    end else begin
      pop_ok  = po && (mq.size() > 0);
      push_ok = pu && ((mq.size() < 8) || pop_ok);
      if (po) begin
        if (pop_ok) m_rd = mq.pop_front();
        else begin m_rd = '0; m_udf = 1; end
      end
      if (push_ok) mq.push_back(w);
      else if (pu) m_ovf = 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    compare_all();
    // R3 R4: fill to eight words, level wraps to 0 and full rises
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 9'(16 + i));
    chk("R3 full reads level 0", level, 0);
    // R5 push on full is dropped
    step(0, 1, 0, 0, 9'h1AA);
    // R7 push and pop together on full keep the new word
    step(0, 1, 1, 0, 9'h155);
    // R2 drain all in order
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, '0);
    // R6 pop empty gives zero and underflow
    step(0, 0, 1, 0, '0);
    chk("R6 empty pop data", rd_data, 0);
    // R7 push and pop on empty: push kept, pop underflows
    step(0, 1, 1, 0, 9'h0F0);
    // R11 hold without pop
    step(0, 0, 0, 0, '0);
    // R10 byte packing
    step(0, 1, 0, 1, 9'h0C3);
    step(0, 0, 1, 0, '0);
    step(0, 0, 1, 0, '0);
    chk("R10 packed byte", rd_data, 9'h187);
    // R8 R9 soft reset with data and a concurrent push/pop
    step(0, 1, 0, 0, 9'h011);
    step(1, 1, 1, 0, 9'h022);
    chk("R9 busy set", busy_err, 1);
    // R9 soft reset on empty clears busy
    step(1, 0, 0, 0, '0);
    chk("R9 busy cleared", busy_err, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom_range(0, 99);
      step(r < 2, ($urandom_range(0, 99) < 55), ($urandom_range(0, 99) < 45),
           ($urandom_range(0, 1) == 1), 9'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule